// File: doc/BRIEF.md
# Walking-One Wiring Continuity Tester

This block exercises a cable harness by driving exactly one of its wires at a time and reading back what arrives at the far end. A start command puts the drive on wire 0. Each step command then moves the drive one wire up without reloading the register. After every start or step, a settle timer waits a fixed number of clocks before it latches the far-end word into a capture register.

The captured word is compared with the one-hot drive word. Each step is reported as a pass, a short (other wires pick up the drive), an open (nothing arrives) or both (the drive is missing and other wires are lit). The block also outputs the raw captured word, a serial copy of that word that the host shifts out one bit per pulse, and the binary index of the wire being driven.

The wire count is a parameter and may be set as high as 300. The host runs the whole test with two commands and reads the results after each capture.

Top module: `harness_walk_tester`

## Requirements
- R1: A start pulse loads the drive word with only bit 0 set and sets the index to 0. It also clears the valid, done and overrun flags. Start has priority over a step in the same cycle.
- R2: An accepted step moves the single set drive bit one position toward the MSB and adds 1 to the index. The rest of the register is not reloaded.
- R3: The capture happens on the clock edge SETTLE_CYC edges after the edge that sampled the start or accepted step. busy_o is high in between. At the capture edge cap_o takes sense_i and valid_o rises. An accepted step clears valid_o.
- R4: Status 2'b00 (pass) means the captured word equals the drive word.
- R5: Status 2'b01 (short) means the driven bit was captured and at least one other bit is also set.
- R6: Status 2'b10 (open) means no bit was captured and the driven bit is missing. Status 2'b11 means the driven bit is missing and some other bit is set.
- R7: A step that arrives while busy_o is high changes neither the drive nor the index. It sets overrun_o, which stays set until the next start.
- R8: done_o rises with the capture made while the last wire (index WIDTH-1) is driven. A step while done_o is high, or before the first start, has no effect and does not set overrun_o.
- R9: With the default LSB-first order, ser_o shows bit 0 of the word just captured. Each ser_shift_i pulse moves the next higher bit onto ser_o, and zeros follow once all bits are out.
- R10: While reset is held, drive_o, index_o, status_o and cap_o are all zero, and busy_o, valid_o, done_o and overrun_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restart the walk at wire 0 |
| step_i | input | 1 | Move the drive to the next wire |
| ser_shift_i | input | 1 | Advance the serial copy by one bit |
| sense_i | input | WIDTH | Far-end wire levels |
| drive_o | output | WIDTH | One-hot near-end drive |
| index_o | output | IDX_W | Index of the driven wire |
| busy_o | output | 1 | Settle delay running, capture pending |
| status_o | output | 2 | Classification of the last capture |
| valid_o | output | 1 | status_o and cap_o belong to the current wire |
| done_o | output | 1 | Last wire has been captured |
| overrun_o | output | 1 | Sticky: a step arrived while a capture was pending |
| cap_o | output | WIDTH | Raw captured far-end word |
| ser_o | output | 1 | Serial output of the captured word |

## Verification
The bench wires a faulty harness into the design: two wires shorted together, one broken wire, and one wire crossed onto its neighbour. This produces all four status codes. A classifier that checks only the bit above the driven one, or that treats an all-zero word as a short, reports the wrong code on some step.

A step is sent while a capture is pending. A design without the guard would advance the drive before latching, so the capture would belong to the wrong wire, and overrun_o would stay low.

Steps are also sent after done_o and before the first start. A design that let them through would wrap the one-hot bit to zero or move it off zero.

Start and step are asserted together, and a second start is issued mid-delay. A timer that is not reloaded would latch early, and the model catches this on the exact capture cycle.

// File: rtl/harness_pkg.sv
package harness_pkg;
  typedef enum logic [1:0] {
    ST_PASS  = 2'b00,
    ST_SHORT = 2'b01,
    ST_OPEN  = 2'b10,
    ST_BOTH  = 2'b11
  } wire_status_e;
endpackage

// File: rtl/hw_walk_drive.sv
module hw_walk_drive #(
  parameter int WIDTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             adv_i,
  output logic [WIDTH-1:0] drive_o,
  output logic [IDX_W-1:0] index_o
);
  localparam logic [WIDTH-1:0] FIRST = WIDTH'(1);

  logic [WIDTH-1:0] drive_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_q <= '0;
      idx_q   <= '0;
    end else if (start_i) begin
      drive_q <= FIRST;
      idx_q   <= '0;
    end else if (adv_i) begin
      drive_q <= drive_q << 1;
      idx_q   <= idx_q + IDX_W'(1);
    end
  end

  assign drive_o = drive_q;
  assign index_o = idx_q;

  assert_drive_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drive_q));
  assert_start_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (drive_q == FIRST) && (idx_q == '0));
  assert_step_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !start_i) |=> (drive_q == ($past(drive_q) << 1)));
endmodule

// File: rtl/hw_settle_timer.sv
module hw_settle_timer #(
  parameter int SETTLE_CYC = 4,
  parameter int CNT_W      = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o,
  output logic fire_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign fire_o = (cnt_q == CNT_W'(1));

  assert_load_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o);
  assert_fire_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !load_i) |=> !busy_o);
endmodule

// File: rtl/hw_fault_classifier.sv
module hw_fault_classifier #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]         word_i,
  input  logic [WIDTH-1:0]         drive_i,
  output harness_pkg::wire_status_e status_o
);
  logic [WIDTH-1:0] hit, extra;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign hit[i]   = word_i[i] & drive_i[i];
    assign extra[i] = word_i[i] & ~drive_i[i];
  end

  logic missing, other;
  assign missing = ~|hit;
  assign other   = |extra;

  always_comb begin
    unique case ({missing, other})
      2'b00:   status_o = harness_pkg::ST_PASS;
      2'b01:   status_o = harness_pkg::ST_SHORT;
      2'b10:   status_o = harness_pkg::ST_OPEN;
      default: status_o = harness_pkg::ST_BOTH;
    endcase
  end
endmodule

// File: rtl/hw_cap_serializer.sv
module hw_cap_serializer #(
  parameter int WIDTH     = 8,
  parameter bit MSB_FIRST = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             shift_i,
  output logic [WIDTH-1:0] cap_o,
  output logic             ser_o
);
  logic [WIDTH-1:0] cap_q, sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cap_q <= '0;
    else if (load_i) cap_q <= word_i;
  end
  assign cap_o = cap_q;

  if (MSB_FIRST) begin : g_msb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sh_q <= '0;
      else if (load_i)   sh_q <= word_i;
      else if (shift_i)  sh_q <= sh_q << 1;
    end
    assign ser_o = sh_q[WIDTH-1];

    assert_ser_shift_msb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_i && !load_i) |=> (sh_q == ($past(sh_q) << 1)));
  end else begin : g_lsb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sh_q <= '0;
      else if (load_i)   sh_q <= word_i;
      else if (shift_i)  sh_q <= sh_q >> 1;
    end
    assign ser_o = sh_q[0];

    assert_ser_shift_lsb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_i && !load_i) |=> (sh_q == ($past(sh_q) >> 1)));
  end

  assert_load_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cap_q == $past(word_i)) && (sh_q == $past(word_i)));
endmodule

// File: rtl/harness_walk_tester.sv
module harness_walk_tester #(
  parameter int WIDTH      = 8,
  parameter int SETTLE_CYC = 4,
  parameter bit MSB_FIRST  = 1'b0,
  localparam int IDX_W     = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int CNT_W     = $clog2(SETTLE_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             ser_shift_i,
  input  logic [WIDTH-1:0] sense_i,
  output logic [WIDTH-1:0] drive_o,
  output logic [IDX_W-1:0] index_o,
  output logic             busy_o,
  output logic [1:0]       status_o,
  output logic             valid_o,
  output logic             done_o,
  output logic             overrun_o,
  output logic [WIDTH-1:0] cap_o,
  output logic             ser_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIDTH - 1);

  logic active_q, done_q, ovr_q, valid_q;
  harness_pkg::wire_status_e status_q, status_d;
  logic busy, fire, capture, step_ok, adv, step_late;

  // a step is only meaningful while a walk is running and not finished
  assign step_ok   = step_i && !start_i && active_q && !done_q;
  assign adv       = step_ok && !busy;
  assign step_late = step_ok && busy;
  assign capture   = fire && !start_i;

  hw_walk_drive #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_drive (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .adv_i   (adv),
    .drive_o (drive_o),
    .index_o (index_o)
  );

  hw_settle_timer #(.SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i || adv),
    .busy_o (busy),
    .fire_o (fire)
  );

  hw_fault_classifier #(.WIDTH(WIDTH)) u_class (
    .word_i   (sense_i),
    .drive_i  (drive_o),
    .status_o (status_d)
  );

  hw_cap_serializer #(.WIDTH(WIDTH), .MSB_FIRST(MSB_FIRST)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (capture),
    .word_i  (sense_i),
    .shift_i (ser_shift_i),
    .cap_o   (cap_o),
    .ser_o   (ser_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      ovr_q    <= 1'b0;
      valid_q  <= 1'b0;
      status_q <= harness_pkg::ST_PASS;
    end else if (start_i) begin
      active_q <= 1'b1;
      done_q   <= 1'b0;
      ovr_q    <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      if (step_late) ovr_q <= 1'b1;
      if (adv)       valid_q <= 1'b0;
      if (capture) begin
        valid_q  <= 1'b1;
        status_q <= status_d;
        if (index_o == LAST_IDX) done_q <= 1'b1;
      end
    end
  end

  assign busy_o    = busy;
  assign status_o  = status_q;
  assign valid_o   = valid_q;
  assign done_o    = done_q;
  assign overrun_o = ovr_q;

  assert_capture_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> valid_o);
  assert_late_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && busy_o && !start_i) |=> $stable(index_o) && $stable(drive_o));
  assert_late_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && busy_o && active_q && !done_o && !start_i) |=> overrun_o);
  assert_ovr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !start_i) |=> overrun_o);
  assert_done_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (index_o == LAST_IDX));
  assert_done_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(drive_o) && !$rose(overrun_o));
  assert_index_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> drive_o[index_o]);
endmodule

// File: tb/harness_walk_tester_tb.sv
`timescale 1ns/1ps
module harness_walk_tester_tb_top;
  localparam int W = 8;
  localparam int S = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, step = 1'b0, ser_shift = 1'b0;
  logic [W-1:0] sense, drive, cap;
  logic [IW-1:0] index;
  logic busy, valid, done, ovr, ser;
  logic [1:0] status;

  always #10 clk = ~clk;

  // fault net: short 1<->2, open on 3, wire 5 crossed onto 6
  bit flt_on = 1'b0;
  function automatic logic [W-1:0] harness(input logic [W-1:0] d);
    logic [W-1:0] s;
    s = d;
    if (flt_on) begin
      if (s[1] | s[2]) begin s[1] = 1'b1; s[2] = 1'b1; end
      s[3] = 1'b0;
      s[6] = s[6] | s[5];
      s[5] = 1'b0;
    end
    return s;
  endfunction

  assign sense = harness(drive);

  harness_walk_tester #(.WIDTH(W), .SETTLE_CYC(S)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .step_i(step),
    .ser_shift_i(ser_shift), .sense_i(sense), .drive_o(drive),
    .index_o(index), .busy_o(busy), .status_o(status), .valid_o(valid),
    .done_o(done), .overrun_o(ovr), .cap_o(cap), .ser_o(ser)
  );

  int checks = 0, errors = 0;
  bit reported = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [W-1:0] m_drv, m_cap, m_sh, m_sense;
  int m_idx, m_cnt;
  bit m_act, m_done, m_ovr, m_valid;
  logic [1:0] m_st;

  function automatic logic [1:0] classify(input logic [W-1:0] w, input int k);
    bit other = 1'b0;
    for (int i = 0; i < W; i++) if (w[i] && i != k) other = 1'b1;
    return {~w[k], other};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_drv = '0; m_cap = '0; m_sh = '0; m_idx = 0; m_cnt = 0;
      m_act = 0; m_done = 0; m_ovr = 0; m_valid = 0; m_st = 2'b00;
    end else begin
      bit cap_now;
      m_sense = harness(m_drv);
      cap_now = (m_cnt == 1) && !start;
      if (cap_now) m_sh = m_sense;
      else if (ser_shift) m_sh = m_sh >> 1;
      if (start) begin
        m_act = 1; m_idx = 0; m_drv = W'(1); m_cnt = S;
        m_valid = 0; m_done = 0; m_ovr = 0;
      end else begin
        if (cap_now) begin
          m_cap = m_sense; m_st = classify(m_sense, m_idx); m_valid = 1;
          if (m_idx == W - 1) m_done = 1;
        end
        if (step && m_act && !m_done) begin
          if (m_cnt != 0) m_ovr = 1;
          else begin
            m_idx++; m_drv = m_drv << 1; m_cnt = S + 1; m_valid = 0;
          end
        end
        if (m_cnt != 0) m_cnt--;
      end
    end
  end

  bit cmp_en = 1'b0;
  always @(negedge clk) if (cmp_en) begin
    chk("R2", "drive", drive, m_drv);
    chk("R2", "index", index, m_idx);
    chk("R3", "busy", busy, m_cnt != 0);
    chk("R3", "valid", valid, m_valid);
    chk("R3", "cap", cap, m_cap);
    chk("R6", "status", status, m_st);
    chk("R8", "done", done, m_done);
    chk("R7", "overrun", ovr, m_ovr);
    chk("R9", "ser", ser, m_sh[0]);
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) start = 1; else if (which == 1) step = 1; else ser_shift = 1;
    @(negedge clk);
    start = 0; step = 0; ser_shift = 0;
  endtask

  task automatic final_report;
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    final_report();
  end

  int exp_st [W] = '{0, 1, 1, 2, 0, 3, 0, 0};

  initial begin
    wait_n(2);
    // R10 reset state
    chk("R10", "drive", drive, 0); chk("R10", "index", index, 0);
    chk("R10", "status", status, 0); chk("R10", "cap", cap, 0);
    chk("R10", "flags", {busy, valid, done, ovr}, 0);
    @(negedge clk) rst_n = 1'b1;
    cmp_en = 1'b1;
    // R8 steps before any start are ignored
    pulse(1); wait_n(1);
    chk("R8", "drive before start", drive, 0);
    chk("R8", "overrun before start", ovr, 0);

    flt_on = 1'b1;
    pulse(0); wait_n(6);
    chk("R1", "drive after start", drive, 8'h01);
    chk("R4", "wire0 status", status, 0);
    for (int w = 1; w < W; w++) begin
      pulse(1); wait_n(6);
      chk("R2", "index after step", index, w);
      chk(exp_st[w] == 1 ? "R5" : (exp_st[w] == 0 ? "R4" : "R6"),
          "status per wire", status, exp_st[w]);
    end
    chk("R8", "done after last", done, 1);
    pulse(1); wait_n(2);
    chk("R8", "drive frozen", drive, 8'h80);
    chk("R8", "no overrun when done", ovr, 0);

    // R7 step during settle
    pulse(0); pulse(1); wait_n(1);
    chk("R7", "overrun set", ovr, 1);
    chk("R7", "index held", index, 0);
    wait_n(5);
    chk("R7", "overrun sticky", ovr, 1);
    pulse(1); wait_n(6);
    chk("R5", "wire1 short", status, 2'b01);
    chk("R3", "cap raw", cap, 8'h06);

    // R9 serial readout
    begin
      logic [W-1:0] got = '0;
      for (int b = 0; b < W; b++) begin
        got[b] = ser;
        pulse(2);
      end
      chk("R9", "serial word", got, 8'h06);
      chk("R9", "zero fill", ser, 0);
    end

    // R1 start with step in the same cycle, then restart mid-delay
    @(negedge clk); start = 1; step = 1;
    @(negedge clk); start = 0; step = 0;
    chk("R1", "start wins index", index, 0);
    chk("R1", "overrun cleared", ovr, 0);
    wait_n(1);
    pulse(0); wait_n(8);
    chk("R3", "capture after restart", valid, 1);
    chk("R4", "wire0 pass", status, 0);
    cmp_en = 1'b0;
    final_report();
  end
endmodule